// File: doc/BRIEF.md
# Muxed Reference Clock Divider

This block turns one of four free-running source tick strobes into two divided reference tick strobes for peripherals. A 32-bit control word chooses the source, sets a 6-bit divide ratio, and carries a separate activity bit for each output. Both outputs share the source choice and the ratio, so they are always in phase. Each output can still be switched off on its own.

The control word is an input that a register bank elsewhere drives, and the block responds to any change in it at once. A single counter counts the selected source ticks. When it reaches the ratio, every enabled output gives a one-cycle strobe. Changing the source or the ratio restarts the count from zero, so a shortened period never appears. While reset is held, both outputs stay low.

Top module: `refclk_div`

## Requirements
- R1: While rst_n is low, both outputs are 0 whatever the control word and the source ticks are.
- R2: Control bits [5:4] choose the source line. Codes 0 and 1 both use src_tick[0], code 2 uses src_tick[2] and code 3 uses src_tick[3]. src_tick[1] is never used.
- R3: With control bits [13:8] = N in 1..63, every enabled output strobes for exactly one cycle for every N selected ticks. The strobe comes in the cycle after the Nth tick.
- R4: A divisor field of 0 gives divide-by-1: every selected tick gives a strobe.
- R5: Control bit 0 enables out_tick[0] and bit 1 enables out_tick[1]. An output whose bit is clear never strobes, while the other output goes on strobing.
- R6: A change to an enable bit applies from the next selected tick and does not restart the count.
- R7: A change to the source or divisor field restarts the count at zero. A tick in the cycle where the change is first seen is dropped.
- R8: Control bits 2, 3, 6, 7 and 14 to 31 have no effect on the outputs or on the count.
- R9: Ticks on source lines that are not selected have no effect on the outputs or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all source ticks are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | One-cycle tick strobes from the four sources |
| ctrl | input | 32 | Control word: enables [1:0], source [5:4], divisor [13:8] |
| out_tick | output | 2 | Divided tick strobes, one per output |

## Verification
The hardest case to reach from the ports is a control change made part-way through a count. A wrong design could keep the old count and still produce strobes at a plausible rate. The bench moves the counter to a known phase and then changes the divisor. It also toggles only the enable bits, and separately only the unrelated bits. In each case it checks the exact tick on which the next strobe arrives. Every divisor/source sweep places noise ticks on all unselected lines between the real ticks, so a wrong source mapping shows up as an early strobe.

// File: rtl/refclk_div.sv
module refclk_div #(
  parameter int          NUM_SRC  = 4,
  parameter int          NUM_OUT  = 2,
  parameter int          SEL_W    = 2,
  parameter int          DIV_W    = 6,
  parameter int          CTRL_W   = 32,
  parameter int          SEL_LSB  = 4,
  parameter int          DIV_LSB  = 8,
  parameter logic [31:0] RST_CTRL = 32'h0000_3F03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [CTRL_W-1:0]  ctrl,
  output logic [NUM_OUT-1:0] out_tick
);

  localparam logic [SEL_W-1:0] SEL_RST = RST_CTRL[SEL_LSB +: SEL_W];
  localparam logic [DIV_W-1:0] DIV_RST = RST_CTRL[DIV_LSB +: DIV_W];

  logic [SEL_W-1:0] sel, sel_q, src_idx;
  logic [DIV_W-1:0] div, div_q, last, cnt;
  logic             tick, chg, fire;
  logic             unused_bits;

  assign sel     = ctrl[SEL_LSB +: SEL_W];
  assign div     = ctrl[DIV_LSB +: DIV_W];
  assign src_idx = (sel == SEL_W'(1)) ? '0 : sel;
  assign tick    = src_tick[src_idx];
  assign last    = (div == '0) ? '0 : div - DIV_W'(1);
  assign chg     = (sel != sel_q) || (div != div_q);
  assign fire    = !chg && tick && (cnt >= last);
  assign unused_bits = ^ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
      div_q <= DIV_RST;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      div_q <= div;
      if (chg)
        cnt <= '0;
      else if (tick)
        cnt <= (cnt >= last) ? '0 : cnt + DIV_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_tick[i] <= 1'b0;
      else        out_tick[i] <= fire && ctrl[i];
    end

    // R5
    out_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick[i] |-> $past(ctrl[i]));
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (out_tick == '0);
  end

  // R9
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_tick) |-> $past(src_tick[src_idx]));

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (out_tick == '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> (cnt <= last));

endmodule

// File: tb/refclk_div_tb.sv
module refclk_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic [31:0] ctrl = 32'h0000_3F03;
  logic [1:0]  out_tick;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  bit          done = 0;

  refclk_div u_dut (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
                    .ctrl(ctrl), .out_tick(out_tick));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got=%0d exp=<finish>", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] mk(int sel, int dv, int en);
    return {18'd0, 6'(dv), 2'b00, 2'(sel), 2'b00, 2'(en)};
  endfunction

  function automatic int line_of(int sel);
    return (sel == 1) ? 0 : sel;
  endfunction

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic step(logic [3:0] t, output logic [1:0] got);
    src_tick = t;
    @(negedge clk);
    got = out_tick;
    src_tick = '0;
  endtask

  task automatic setc(logic [31:0] c);
    logic [1:0] g;
    ctrl = c;
    step(4'b0000, g);
    check("R7 idle", g, 2'b00);
  endtask

  initial begin
    logic [1:0] g;
    int divs[6] = '{0, 1, 2, 3, 7, 63};
    @(negedge clk);
    ctrl = mk(0, 0, 3);
    for (int i = 0; i < 4; i++) begin
      step(4'b1111, g);
      check("R1 reset", g, 2'b00);
    end
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 6; d++) begin
        int n  = (divs[d] == 0) ? 1 : divs[d];
        int en = (s + d) % 4;
        logic [3:0] sel_m = 4'(1 << line_of(s));
        setc(mk(s, divs[d], en));
        for (int k = 1; k <= 2 * n + 1; k++) begin
          step(~sel_m, g);
          check("R9 noise", g, 2'b00);
          step(sel_m, g);
          check(divs[d] == 0 ? "R4 div0" : (s < 2 ? "R2 R3 sel" : "R3 R5"),
                g, (k % n == 0) ? 2'(en) : 2'b00);
        end
      end
    end

    setc(mk(2, 5, 3));
    step(4'b0100, g); step(4'b0100, g);
    setc(mk(2, 3, 3));
    for (int k = 1; k <= 3; k++) begin
      step(4'b0100, g);
      check("R7 restart", g, (k == 3) ? 2'b11 : 2'b00);
    end
    ctrl = mk(2, 4, 3);
    step(4'b0100, g);
    check("R7 dropped", g, 2'b00);
    for (int k = 1; k <= 4; k++) begin
      step(4'b0100, g);
      check("R7 after", g, (k == 4) ? 2'b11 : 2'b00);
    end

    setc(mk(3, 4, 1));
    step(4'b1000, g); step(4'b1000, g);
    check("R6 pre", g, 2'b00);
    ctrl = mk(3, 4, 2);
    step(4'b1000, g);
    check("R6 mid", g, 2'b00);
    step(4'b1000, g);
    check("R6 en", g, 2'b10);

    setc(mk(0, 3, 3));
    step(4'b0001, g);
    ctrl = mk(0, 3, 3) | 32'hFFFF_C0CC;
    step(4'b0001, g);
    check("R8 mid", g, 2'b00);
    step(4'b0001, g);
    check("R8 ignore", g, 2'b11);

    step(4'b0001, g);
    rst_n = 1'b0;
    step(4'b1111, g);
    check("R1 reset again", g, 2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule